// File: doc/BRIEF.md
# Clock generator mode control

This block keeps the control and status state of an on-chip clock generator. Configuration options are loaded once after reset and stay fixed until the next reset. They decide three things: whether the external clock path may be switched on, whether an external crystal needs a long start-up count, and whether the generator keeps running while the device is in stop. Software writes a control register with the clock select, the two oscillator enables and the monitor controls, and a tuning register that holds the multiplier, trim and divider fields as one word.

A counter in the external clock domain measures how long the external source has been running. Its completion is brought back into the bus clock domain through a two-flop synchronizer and shows up as the external stable flag. A stop request either freezes the generator or leaves it running, depending on the stop option. In the frozen case the generator drops its clock enables and clears the stable and monitor state. It keeps the selection and tuning fields, so that the stabilization count runs again after wakeup.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: After reset, `cfg_q`, `ctl_q`, `tune_q`, `ext_stable`, `int_stable`, `mon_flag`, `mon_irq`, `in_stop`, `osc1_clk_sel` and `osc2_amp_en` are all 0, and `clk_en` is all ones.
- R2: The first `cfg_load` strobe after reset copies `cfg_wdata` into `cfg_q`. The bits are 0 = external clock allowed, 1 = crystal, 2 = run in stop. Every later strobe is ignored until the next reset.
- R3: A control write sets `ctl_q` bit 2 (external clock on) only when `cfg_q` bit 0 is 1. Otherwise the bit reads 0. The write data bits are 0 = clock select, 1 = internal on, 2 = external on, 3 = monitor enable, 4 = monitor interrupt enable, 5 = clear monitor flag. `ctl_q` holds bits 0 to 4 in the same positions.
- R4: `osc1_clk_sel` is 1 exactly when the external clock is allowed and on. `osc2_amp_en` is 1 exactly when, in addition, the crystal option is set.
- R5: With the external clock on, `ext_stable` rises only after more than 4096 `ext_clk` rising edges (crystal option set) or more than 16 (crystal option clear). It then rises within 6 further edges plus 4 bus cycles. It is 0 whenever the external clock is off.
- R6: While in stop with the run-in-stop option clear, all bits of `clk_en` are 0. With the option set, they stay all ones.
- R7: Entering stop with the run-in-stop option clear clears `ext_stable`, `int_stable`, `mon_flag`, the monitor enable and the monitor interrupt enable on the next edge. It keeps the clock select, both oscillator on bits and `tune_q`.
- R8: Entering stop with the run-in-stop option set leaves every control bit, the tuning word and all status flags unchanged.
- R9: A write of the monitor interrupt enable takes effect only together with the monitor enable. Whenever the monitor enable is 0, the interrupt enable and `mon_flag` are 0.
- R10: `mon_flag` sets on the edge after `mon_fault` is seen while the monitor is enabled. It stays set until a control write with data bit 5 at 1, and a set in the same cycle wins over that clear.
- R11: `mon_irq` is `mon_flag` AND the monitor interrupt enable outside stop, and is 0 in stop. It never causes a stop exit.
- R12: `wake_ext` always ends stop. `wake_tbm` ends stop only when the run-in-stop option is set.
- R13: `int_stable` is 1 on the edge after the internal oscillator is on and `int_osc_ready` is 1, provided the generator is not frozen in stop. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External clock being qualified |
| cfg_load | input | 1 | One-time configuration load strobe |
| cfg_wdata | input | 3 | Configuration option bits |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control write data |
| tune_wr | input | 1 | Tuning word write strobe |
| tune_wdata | input | TUNE_W | Tuning word write data |
| stop_req | input | 1 | Request to enter stop |
| wake_ext | input | 1 | Wakeup that is always honoured |
| wake_tbm | input | 1 | Timebase wakeup |
| int_osc_ready | input | 1 | Internal oscillator reports it is running |
| mon_fault | input | 1 | Clock monitor detected a fault |
| cfg_q | output | 3 | Loaded configuration options |
| ctl_q | output | 5 | Control register contents |
| tune_q | output | TUNE_W | Tuning word |
| ext_stable | output | 1 | External clock stable flag |
| int_stable | output | 1 | Internal clock stable flag |
| mon_flag | output | 1 | Sticky clock monitor flag |
| mon_irq | output | 1 | Monitor interrupt request |
| in_stop | output | 1 | Device is in stop |
| clk_en | output | 4 | Enables for main, bus, watchdog and timebase clocks |
| osc1_clk_sel | output | 1 | First oscillator pin used as clock input |
| osc2_amp_en | output | 1 | Crystal amplifier drives the second oscillator pin |

## Verification
Some rules hold on every cycle, and the embedded properties watch those. The external on bit never appears without its configuration permission. The monitor flag and the interrupt enable never outlive the monitor enable. External stability never outlasts the external on bit. The stabilization count stays within its limit. A frozen stop entry wipes the volatile state and keeps the rest. Neither a pending interrupt nor a timebase wakeup ends a frozen stop. The cross-domain timing needs the bench scenarios: the 16 and 4096 edge windows, the rerun after a frozen stop, and the different treatment of the two wakeups under each stop option. The bench also shows that configuration is write-once and that a set and a clear in the same cycle resolve in favour of the set.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  localparam int CFG_W = 3;
  localparam int CFG_EXT_EN   = 0;
  localparam int CFG_XTAL     = 1;
  localparam int CFG_STOP_OSC = 2;

  localparam int CTL_W = 6;
  localparam int CTL_SEL     = 0;
  localparam int CTL_INT_ON  = 1;
  localparam int CTL_EXT_ON  = 2;
  localparam int CTL_MON_EN  = 3;
  localparam int CTL_MON_IE  = 4;
  localparam int CTL_MON_CLR = 5;

  localparam int NUM_CLK_EN = 4;

  typedef struct packed {
    logic stop_osc;
    logic xtal;
    logic ext_en;
  } cfg_t;

  typedef struct packed {
    logic mon_ie;
    logic mon_en;
    logic ext_on;
    logic int_on;
    logic clk_sel;
  } ctl_t;

  localparam int CTL_Q_W = $bits(ctl_t);

  function automatic int unsigned stab_limit(logic xtal, int unsigned long_n,
                                             int unsigned short_n);
    return xtal ? long_n : short_n;
  endfunction

  function automatic ctl_t ctl_apply(ctl_t cur, logic wr, logic [CTL_W-1:0] wd,
                                     logic ext_ok);
    ctl_t nx;
    nx = cur;
    if (wr) begin
      nx.clk_sel = wd[CTL_SEL];
      nx.int_on  = wd[CTL_INT_ON];
      nx.ext_on  = wd[CTL_EXT_ON] & ext_ok;
      nx.mon_en  = wd[CTL_MON_EN];
      nx.mon_ie  = wd[CTL_MON_IE] & wd[CTL_MON_EN];
    end
    return nx;
  endfunction

endpackage

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/clkgen_stab_cnt.sv
module clkgen_stab_cnt import clkgen_pkg::*; #(
  parameter int unsigned LONG_N  = 4096,
  parameter int unsigned SHORT_N = 16,
  parameter int          SYNC_N  = 2
) (
  input  logic ext_clk,
  input  logic rst_n,
  input  logic arm,
  input  logic xtal,
  output logic done
);
  localparam int CNT_W = $clog2(LONG_N + 1);

  logic             arm_x;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             last_tick;

  clkgen_sync #(.STAGES(SYNC_N)) i_arm_sync (
    .clk(ext_clk), .rst_n(rst_n), .d(arm), .q(arm_x)
  );

  assign limit     = CNT_W'(stab_limit(xtal, LONG_N, SHORT_N));
  assign last_tick = arm_x && !done && (cnt == limit - CNT_W'(1));

  always_ff @(posedge ext_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!arm_x) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt  <= cnt + CNT_W'(1);
      done <= last_tick;
    end
  end

  assert_cnt_bound_R5: assert property (@(posedge ext_clk) disable iff (!rst_n)
    cnt <= limit);
  assert_done_at_limit_R5: assert property (@(posedge ext_clk) disable iff (!rst_n)
    $rose(done) |-> cnt == limit);
endmodule

// File: rtl/clkgen_regs.sv
module clkgen_regs import clkgen_pkg::*; #(
  parameter int TUNE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              tune_wr,
  input  logic [TUNE_W-1:0] tune_wdata,
  input  logic              stop_req,
  input  logic              wake_ext,
  input  logic              wake_tbm,
  input  logic              int_osc_ready,
  input  logic              mon_fault,
  input  logic              ext_done_sync,
  output cfg_t              cfg_q,
  output ctl_t              ctl_q,
  output logic [TUNE_W-1:0] tune_q,
  output logic              in_stop,
  output logic              halted,
  output logic              ext_stable,
  output logic              int_stable,
  output logic              mon_flag,
  output logic              stab_arm
);
  logic cfg_done;
  logic seen_low;

  // named events, visible to the properties below
  logic stop_enter, halt_enter, wake_ok, mon_set, mon_clr;
  logic in_stop_nx, halted_nx, flag_nx, int_nx, arm_nx, seen_nx, ext_nx;
  ctl_t ctl_nx;

  always_comb begin
    stop_enter = stop_req & ~in_stop;
    halt_enter = stop_enter & ~cfg_q.stop_osc;
    wake_ok    = wake_ext | (wake_tbm & cfg_q.stop_osc);
    in_stop_nx = in_stop ? ~wake_ok : stop_req;
    halted_nx  = in_stop_nx & ~cfg_q.stop_osc;

    ctl_nx = ctl_apply(ctl_q, ctl_wr, ctl_wdata, cfg_q.ext_en);
    if (halted_nx) begin
      ctl_nx.mon_en = 1'b0;
      ctl_nx.mon_ie = 1'b0;
    end

    mon_set = ctl_q.mon_en & mon_fault;
    mon_clr = ctl_wr & ctl_wdata[CTL_MON_CLR];
    flag_nx = ctl_nx.mon_en & (mon_set | (mon_flag & ~mon_clr));

    int_nx  = ctl_nx.int_on & int_osc_ready & ~halted_nx;

    arm_nx  = ctl_nx.ext_on & ~halted_nx;
    seen_nx = arm_nx & (seen_low | ~ext_done_sync);
    ext_nx  = arm_nx & (ext_stable | (seen_low & ext_done_sync));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      cfg_done <= 1'b0;
    end else if (cfg_load && !cfg_done) begin
      cfg_q    <= cfg_t'(cfg_wdata);
      cfg_done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tune_q <= '0;
    else if (tune_wr) tune_q <= tune_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      in_stop    <= 1'b0;
      mon_flag   <= 1'b0;
      int_stable <= 1'b0;
      stab_arm   <= 1'b0;
      seen_low   <= 1'b0;
      ext_stable <= 1'b0;
    end else begin
      ctl_q      <= ctl_nx;
      in_stop    <= in_stop_nx;
      mon_flag   <= flag_nx;
      int_stable <= int_nx;
      stab_arm   <= arm_nx;
      seen_low   <= seen_nx;
      ext_stable <= ext_nx;
    end
  end

  assign halted = in_stop & ~cfg_q.stop_osc;

  assert_ext_on_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.ext_on |-> cfg_q.ext_en);
  assert_ext_stable_needs_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_stable |-> ctl_q.ext_on);
  assert_halt_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_enter |=> (!ext_stable && !int_stable && !mon_flag && !ctl_q.mon_en && !ctl_q.mon_ie));
  assert_halt_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_enter && !ctl_wr && !tune_wr) |=>
      ($stable(tune_q) && $stable(ctl_q.clk_sel) && $stable(ctl_q.int_on) && $stable(ctl_q.ext_on)));
  assert_mon_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_flag || ctl_q.mon_ie) |-> ctl_q.mon_en);
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_flag && !ctl_wr && !halt_enter && !(in_stop && !cfg_q.stop_osc)) |=> mon_flag);
  assert_irq_no_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && !wake_ext && !wake_tbm) |=> in_stop);
  assert_tbm_blocked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && !cfg_q.stop_osc && !wake_ext) |=> in_stop);
endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl import clkgen_pkg::*; #(
  parameter int          TUNE_W  = 20,
  parameter int unsigned LONG_N  = 4096,
  parameter int unsigned SHORT_N = 16,
  parameter int          SYNC_N  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ext_clk,
  input  logic                  cfg_load,
  input  logic [CFG_W-1:0]      cfg_wdata,
  input  logic                  ctl_wr,
  input  logic [CTL_W-1:0]      ctl_wdata,
  input  logic                  tune_wr,
  input  logic [TUNE_W-1:0]     tune_wdata,
  input  logic                  stop_req,
  input  logic                  wake_ext,
  input  logic                  wake_tbm,
  input  logic                  int_osc_ready,
  input  logic                  mon_fault,
  output logic [CFG_W-1:0]      cfg_q,
  output logic [CTL_Q_W-1:0]    ctl_q,
  output logic [TUNE_W-1:0]     tune_q,
  output logic                  ext_stable,
  output logic                  int_stable,
  output logic                  mon_flag,
  output logic                  mon_irq,
  output logic                  in_stop,
  output logic [NUM_CLK_EN-1:0] clk_en,
  output logic                  osc1_clk_sel,
  output logic                  osc2_amp_en
);
  cfg_t cfg_s;
  ctl_t ctl_s;
  logic halted, stab_arm, ext_done, ext_done_sync;

  clkgen_regs #(.TUNE_W(TUNE_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_wdata(cfg_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .tune_wr(tune_wr), .tune_wdata(tune_wdata),
    .stop_req(stop_req), .wake_ext(wake_ext), .wake_tbm(wake_tbm),
    .int_osc_ready(int_osc_ready), .mon_fault(mon_fault), .ext_done_sync(ext_done_sync),
    .cfg_q(cfg_s), .ctl_q(ctl_s), .tune_q(tune_q), .in_stop(in_stop), .halted(halted),
    .ext_stable(ext_stable), .int_stable(int_stable), .mon_flag(mon_flag),
    .stab_arm(stab_arm)
  );

  clkgen_stab_cnt #(.LONG_N(LONG_N), .SHORT_N(SHORT_N), .SYNC_N(SYNC_N)) i_stab (
    .ext_clk(ext_clk), .rst_n(rst_n), .arm(stab_arm), .xtal(cfg_s.xtal), .done(ext_done)
  );

  clkgen_sync #(.STAGES(SYNC_N)) i_done_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_done), .q(ext_done_sync)
  );

  generate
    for (genvar g = 0; g < NUM_CLK_EN; g++) begin : g_clk_en
      assign clk_en[g] = ~halted;
    end
  endgenerate

  assign cfg_q        = cfg_s;
  assign ctl_q        = ctl_s;
  assign osc1_clk_sel = cfg_s.ext_en & ctl_s.ext_on;
  assign osc2_amp_en  = cfg_s.xtal & osc1_clk_sel;
  assign mon_irq      = mon_flag & ctl_s.mon_ie & ~in_stop;

  assert_amp_needs_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    osc2_amp_en |-> (ctl_s.ext_on && cfg_s.xtal));
  assert_run_in_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && cfg_s.stop_osc) |-> (clk_en == '1));
endmodule

// File: tb/test_clkgen_mode_ctrl.sv
`timescale 1ns/1ps
module test_clkgen_mode_ctrl;
  localparam int TW = 20;

  logic clk = 0, ext_clk = 0, rst_n = 0;
  logic cfg_load = 0, ctl_wr = 0, tune_wr = 0, stop_req = 0;
  logic wake_ext = 0, wake_tbm = 0, int_osc_ready = 0, mon_fault = 0;
  logic [2:0] cfg_wdata = 0;
  logic [5:0] ctl_wdata = 0;
  logic [TW-1:0] tune_wdata = 0;
  logic [2:0] cfg_q;
  logic [4:0] ctl_q;
  logic [TW-1:0] tune_q;
  logic ext_stable, int_stable, mon_flag, mon_irq, in_stop, osc1_clk_sel, osc2_amp_en;
  logic [3:0] clk_en;

  int n_chk = 0, n_bad = 0;

  clkgen_mode_ctrl #(.TUNE_W(TW)) i_clkgen_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .cfg_load(cfg_load), .cfg_wdata(cfg_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .tune_wr(tune_wr), .tune_wdata(tune_wdata),
    .stop_req(stop_req), .wake_ext(wake_ext), .wake_tbm(wake_tbm),
    .int_osc_ready(int_osc_ready), .mon_fault(mon_fault), .cfg_q(cfg_q), .ctl_q(ctl_q),
    .tune_q(tune_q), .ext_stable(ext_stable), .int_stable(int_stable), .mon_flag(mon_flag),
    .mon_irq(mon_irq), .in_stop(in_stop), .clk_en(clk_en), .osc1_clk_sel(osc1_clk_sel),
    .osc2_amp_en(osc2_amp_en)
  );

  always #5 clk = ~clk;
  initial begin #2; forever #15 ext_clk = ~ext_clk; end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bench-side expectation functions (bit 4..0 = mon_ie, mon_en, ext_on, int_on, sel)
  function automatic logic [4:0] exp_ctl(logic [4:0] cur, logic wr, logic [5:0] wd, logic allow);
    if (!wr) return cur;
    return {wd[3] && wd[4], wd[3], allow && wd[2], wd[1], wd[0]};
  endfunction

  function automatic logic exp_flag(logic old_flag, logic old_en, logic new_en,
                                    logic fault, logic clr);
    if (!new_en) return 1'b0;
    if (old_en && fault) return 1'b1;
    return clr ? 1'b0 : old_flag;
  endfunction

  task automatic do_reset();
    rst_n = 0; cfg_load = 0; ctl_wr = 0; tune_wr = 0; stop_req = 0;
    wake_ext = 0; wake_tbm = 0; mon_fault = 0; int_osc_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic load_cfg(input logic [2:0] v);
    @(negedge clk); cfg_load = 1; cfg_wdata = v;
    @(negedge clk); cfg_load = 0;
  endtask

  task automatic write_ctl(input logic [5:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  task automatic check_stab(input int limit, input string tag);
    repeat (limit) @(posedge ext_clk);
    #2 chk({tag, " not yet stable"}, ext_stable, 0);
    repeat (6) @(posedge ext_clk);
    repeat (4) @(negedge clk);
    chk({tag, " stable"}, ext_stable, 1);
  endtask

  task automatic rand_phase(input int cycles, input logic allow);
    logic [4:0] m_ctl = 0;
    logic m_flag = 0, m_int = 0;
    logic [4:0] n_ctl;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk("R3 R9 ctl_q", ctl_q, m_ctl);
      chk("R10 mon_flag", mon_flag, m_flag);
      chk("R11 mon_irq", mon_irq, m_flag & m_ctl[4]);
      chk("R13 int_stable", int_stable, m_int);
      ctl_wr = ($urandom % 4) == 0;
      ctl_wdata = 6'($urandom);
      mon_fault = ($urandom % 3) == 0;
      int_osc_ready = 1'($urandom);
      n_ctl = exp_ctl(m_ctl, ctl_wr, ctl_wdata, allow);
      m_flag = exp_flag(m_flag, m_ctl[3], n_ctl[3], mon_fault, ctl_wr && ctl_wdata[5]);
      m_int = n_ctl[1] && int_osc_ready;
      m_ctl = n_ctl;
    end
    @(negedge clk); ctl_wr = 0; mon_fault = 0;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R1 reset state
    chk("R1 cfg_q", cfg_q, 0);   chk("R1 ctl_q", ctl_q, 0);   chk("R1 tune_q", tune_q, 0);
    chk("R1 flags", {ext_stable, int_stable, mon_flag, mon_irq, in_stop}, 0);
    chk("R1 clk_en", clk_en, 4'hF);
    chk("R1 pins", {osc1_clk_sel, osc2_amp_en}, 0);

    // R3: options never loaded, external on refused
    write_ctl(6'b000100);
    chk("R3 ext_on refused", ctl_q[2], 0);
    chk("R3 osc1 port", osc1_clk_sel, 0);
    rand_phase(150, 1'b0);

    // R2 write-once
    do_reset();
    load_cfg(3'b001);
    load_cfg(3'b110);
    chk("R2 cfg write-once", cfg_q, 3'b001);
    rand_phase(250, 1'b1);

    // R9 / R10 directed
    write_ctl(6'b010000);
    chk("R9 ie without en", ctl_q, 0);
    write_ctl(6'b001000);
    @(negedge clk); mon_fault = 1; ctl_wr = 1; ctl_wdata = 6'b101000;
    @(negedge clk); mon_fault = 0; ctl_wr = 0;
    chk("R10 set wins over clear", mon_flag, 1);
    repeat (3) @(negedge clk);
    chk("R10 sticky", mon_flag, 1);
    write_ctl(6'b101000);
    chk("R10 write-1 clear", mon_flag, 0);
    pulse(mon_fault);
    write_ctl(6'b000000);
    chk("R9 en off clears flag", mon_flag, 0);

    // R4 + R5 long count
    do_reset();
    load_cfg(3'b011);
    write_ctl(6'b000100);
    chk("R4 osc1 sel", osc1_clk_sel, 1);
    chk("R4 amp", osc2_amp_en, 1);
    check_stab(4096, "R5 crystal");
    write_ctl(6'b000000);
    chk("R4 amp off", osc2_amp_en, 0);
    chk("R5 cleared when off", ext_stable, 0);

    // R6 R7 R12 R13: frozen stop
    do_reset();
    load_cfg(3'b001);
    int_osc_ready = 1;
    write_ctl(6'b011111);
    chk("R4 no amp without crystal", {osc1_clk_sel, osc2_amp_en}, 2'b10);
    check_stab(16, "R5 short");
    chk("R13 int_stable", int_stable, 1);
    pulse(mon_fault);
    chk("R11 irq", mon_irq, 1);
    @(negedge clk); tune_wr = 1; tune_wdata = 20'hABCDE;
    @(negedge clk); tune_wr = 0;
    pulse(stop_req);
    chk("R6 in_stop", in_stop, 1);
    chk("R6 clocks off", clk_en, 0);
    chk("R7 stable cleared", {ext_stable, int_stable, mon_flag}, 0);
    chk("R7 ctl kept/cleared", ctl_q, 5'b00111);
    chk("R7 tune kept", tune_q, 20'hABCDE);
    chk("R11 no irq in stop", mon_irq, 0);
    pulse(wake_tbm);
    chk("R12 tbm ignored when frozen", in_stop, 1);
    pulse(wake_ext);
    chk("R12 ext wake", in_stop, 0);
    chk("R6 clocks back", clk_en, 4'hF);
    chk("R13 int restable", int_stable, 1);
    chk("R5 rerun starts clear", ext_stable, 0);
    check_stab(16, "R5 rerun");

    // R6 R8 R11 R12: running stop
    do_reset();
    load_cfg(3'b101);
    int_osc_ready = 1;
    write_ctl(6'b011111);
    check_stab(16, "R5 short2");
    pulse(mon_fault);
    pulse(stop_req);
    chk("R6 running clocks", clk_en, 4'hF);
    chk("R8 ctl kept", ctl_q, 5'b11111);
    chk("R8 flags kept", {ext_stable, int_stable, mon_flag}, 3'b111);
    chk("R11 irq masked", mon_irq, 0);
    repeat (5) @(negedge clk);
    chk("R11 irq no wake", in_stop, 1);
    pulse(wake_tbm);
    chk("R12 tbm wake", in_stop, 0);
    chk("R11 irq after wake", mon_irq, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule